// File: doc/BRIEF.md
# Input/Output Reading Address Counter

This block keeps the address of stored readings. A store first takes in 50 readings in its input phase and then gives out 50 readings in its output phase. The reading address is split into a units decade counter and a tens counter. The tens bits are weighted 10, 20 and 40. A phase flip-flop records whether the store is taking readings in or giving them out. Each raw count pulse is stretched to a fixed window, which is a parameter in clock cycles, and is counted only when the scanner gate allows it. Further raw edges that arrive inside that window are ignored.

The address runs 1 through 50. The count that follows the 50th reading is the wrap. It returns the address to 1, emits a one-clock reset pulse and updates the phase. Without hold, the phase alternates on each wrap. An input-hold line keeps the store in the input phase. A preset trigger arms a one-shot override, and the override sends the next wrap into the output phase. A skip request drops the units digit back to its start, so that one reading is skipped after a transfer. A storage flag marks the output phase. A status flag repeats the reset pulse while input-hold is active.

Top module: `rdaddr_counter`

## Requirements
- R1: After reset, units_o=0, tens_o=0, phase_o=1 (input phase), and storage_flag_o, wrap_o and status_o are all 0.
- R2: A rising edge on cnt_pulse_i while the stretcher is idle and scan_gate_i is 1 advances the address by one. The new address is visible in the cycle after the clock edge that sampled the rising edge.
- R3: A rising edge is not counted if scan_gate_i is 0 when it is sampled. A rising edge is also not counted if it arrives within STRETCH_CYC-1 cycles after an accepted edge. The address stays unchanged in both cases.
- R4: units_o counts 0..9 and carries into tens_o. tens_o is binary, with bit0 weighted 10, bit1 weighted 20 and bit2 weighted 40, so the address equals 10*tens_o + units_o.
- R5: The count after address 50 (tens_o=5, units_o=0) is a wrap. It sets the address to 1 and raises wrap_o for exactly one cycle, in the same cycle as the new address.
- R6: On a wrap with in_hold_i=0 and no armed override, phase_o toggles. phase_o=1 is the input phase and phase_o=0 is the output phase. phase_o changes only on a wrap.
- R7: On a wrap with in_hold_i=1 and no armed override, phase_o becomes 1.
- R8: A 1 on any bit of preset_i arms the override. The next wrap forces phase_o to 0, even under in_hold_i, and disarms the override. Later wraps follow R6 or R7 again.
- R9: storage_flag_o is 1 exactly while phase_o is 0.
- R10: status_o pulses together with wrap_o when in_hold_i was 1 at the wrap. It stays 0 on other wraps.
- R11: skip_i=1 sets units_o to 0 on the next clock and leaves tens_o and phase_o unchanged. A count sampled in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pulse_i | input | 1 | Raw reading count pulse |
| scan_gate_i | input | 1 | Scanner enable for counting |
| in_hold_i | input | 1 | Keep the store in the input phase |
| preset_i | input | NPRESET (3) | Preset trigger lines |
| skip_i | input | 1 | Reset the units digit to skip a reading |
| units_o | output | 4 | Units address digit |
| tens_o | output | 3 | Tens address, weights 10/20/40 |
| phase_o | output | 1 | 1 = input phase, 0 = output phase |
| storage_flag_o | output | 1 | High during the output phase |
| wrap_o | output | 1 | One-clock wrap reset pulse |
| status_o | output | 1 | Wrap pulse repeated while input-hold is active |

## Verification
The hardest condition to reach from the ports is an armed preset override meeting a wrap. That wrap only comes after 50 accepted, correctly spaced and gated counts. It has to be seen while input-hold is active, and then again on the wrap after it, to show that the override acted only once. The bench drives long chains of counts spaced past the stretch window. It keeps its own running address, phase and armed state, so every count in a chain of several hundred is checked, including each wrap. Preset pulses and hold changes are placed in the middle of those chains.

// File: rtl/rdaddr_pkg.sv
package rdaddr_pkg;

  // Linear reading address from the two digits.
  function automatic int unsigned addr_value(input int unsigned units,
                                             input int unsigned tens);
    return tens * 10 + units;
  endfunction

  // True when the digits hold the last address of a phase.
  function automatic logic at_last(input int unsigned units,
                                   input int unsigned tens,
                                   input int unsigned tens_max);
    return (tens == tens_max) && (units == 0);
  endfunction

  // Phase chosen by a wrap: override first, then hold, else toggle.
  function automatic logic wrap_phase(input logic cur, input logic hold,
                                      input logic armed);
    if (armed)     return 1'b0;
    else if (hold) return 1'b1;
    else           return ~cur;
  endfunction

endpackage

// File: rtl/rdaddr_stretch.sv
module rdaddr_stretch #(
  parameter int STRETCH_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic gate_i,
  output logic busy_o,
  output logic count_o
);
  localparam int CW = $clog2(STRETCH_CYC + 1);

  logic          raw_q;
  logic [CW-1:0] win_cnt;
  logic          start;

  assign busy_o  = (win_cnt != '0);
  assign start   = raw_i & ~raw_q & ~busy_o;
  assign count_o = start & gate_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      win_cnt <= '0;
    end else begin
      raw_q <= raw_i;
      if (start)       win_cnt <= CW'(STRETCH_CYC - 1);
      else if (busy_o) win_cnt <= win_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rdaddr_units.sv
module rdaddr_units #(
  parameter int UNITS_MOD = 10,
  localparam int UW = $clog2(UNITS_MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          clear_i,
  input  logic          wrap_i,
  output logic [UW-1:0] units_o,
  output logic          carry_o
);
  logic top_digit;

  assign top_digit = (units_o == UW'(UNITS_MOD - 1));
  assign carry_o   = step_i & ~clear_i & ~wrap_i & top_digit;

  always_ff @(posedge clk) begin
    if (!rst_n)         units_o <= '0;
    else if (clear_i)   units_o <= '0;
    else if (step_i) begin
      if (wrap_i)         units_o <= UW'(1);
      else if (top_digit) units_o <= '0;
      else                units_o <= units_o + 1'b1;
    end
  end
endmodule

// File: rtl/rdaddr_tens_phase.sv
module rdaddr_tens_phase
  import rdaddr_pkg::*;
#(
  parameter int TENS_MAX = 5,
  parameter int NPRESET  = 3,
  localparam int TW = $clog2(TENS_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               carry_i,
  input  logic               wrap_i,
  input  logic               hold_i,
  input  logic [NPRESET-1:0] preset_i,
  output logic [TW-1:0]      tens_o,
  output logic               phase_o,
  output logic               armed_o
);
  logic any_preset;

  assign any_preset = |preset_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tens_o  <= '0;
      phase_o <= 1'b1;
      armed_o <= 1'b0;
    end else begin
      if (wrap_i)       tens_o <= '0;
      else if (carry_i) tens_o <= tens_o + 1'b1;

      if (wrap_i) phase_o <= wrap_phase(phase_o, hold_i, armed_o);

      if (any_preset)  armed_o <= 1'b1;
      else if (wrap_i) armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rdaddr_counter.sv
module rdaddr_counter
  import rdaddr_pkg::*;
#(
  parameter int STRETCH_CYC = 500,
  parameter int UNITS_MOD   = 10,
  parameter int TENS_MAX    = 5,
  parameter int NPRESET     = 3,
  localparam int UW = $clog2(UNITS_MOD),
  localparam int TW = $clog2(TENS_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_pulse_i,
  input  logic               scan_gate_i,
  input  logic               in_hold_i,
  input  logic [NPRESET-1:0] preset_i,
  input  logic               skip_i,
  output logic [UW-1:0]      units_o,
  output logic [TW-1:0]      tens_o,
  output logic               phase_o,
  output logic               storage_flag_o,
  output logic               wrap_o,
  output logic               status_o
);
  // Named internal events.
  logic count_ev;
  logic step_ev;
  logic wrap_ev;
  logic carry_ev;
  logic stretch_busy;
  logic armed;

  rdaddr_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (cnt_pulse_i),
    .gate_i  (scan_gate_i),
    .busy_o  (stretch_busy),
    .count_o (count_ev)
  );

  assign step_ev = count_ev & ~skip_i;
  assign wrap_ev = step_ev & at_last(int'(units_o), int'(tens_o), TENS_MAX);

  rdaddr_units #(.UNITS_MOD(UNITS_MOD)) u_units (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (count_ev),
    .clear_i (skip_i),
    .wrap_i  (wrap_ev),
    .units_o (units_o),
    .carry_o (carry_ev)
  );

  rdaddr_tens_phase #(.TENS_MAX(TENS_MAX), .NPRESET(NPRESET)) u_tens (
    .clk      (clk),
    .rst_n    (rst_n),
    .carry_i  (carry_ev),
    .wrap_i   (wrap_ev),
    .hold_i   (in_hold_i),
    .preset_i (preset_i),
    .tens_o   (tens_o),
    .phase_o  (phase_o),
    .armed_o  (armed)
  );

  assign storage_flag_o = ~phase_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrap_o   <= 1'b0;
      status_o <= 1'b0;
    end else begin
      wrap_o   <= wrap_ev;
      status_o <= wrap_ev & in_hold_i;
    end
  end
endmodule

// File: rtl/rdaddr_counter_chk.sv
module rdaddr_counter_chk #(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MAX  = 5,
  parameter int UW = 4,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_hold_i,
  input logic          skip_i,
  input logic [UW-1:0] units_o,
  input logic [TW-1:0] tens_o,
  input logic          phase_o,
  input logic          storage_flag_o,
  input logic          wrap_o,
  input logic          status_o
);
  // R4: digits stay in their ranges
  assert_units_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    units_o < UW'(UNITS_MOD));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_o == TW'(TENS_MAX)) |-> (units_o == '0));
  // R5: wrap lands on address 1 and lasts one cycle
  assert_wrap_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (units_o == UW'(1) && tens_o == '0));
  assert_wrap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);
  // R6: phase moves only on a wrap
  assert_phase_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> wrap_o);
  // R9: storage flag marks output phase
  assert_flag_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    storage_flag_o == !phase_o);
  // R10: status only with a held wrap
  assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_o |-> (wrap_o && $past(in_hold_i)));
  // R11: skip clears units, keeps tens and phase
  assert_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(skip_i) |-> (units_o == '0 && tens_o == $past(tens_o)
                       && phase_o == $past(phase_o)));
endmodule

bind rdaddr_counter rdaddr_counter_chk #(
  .UNITS_MOD(UNITS_MOD), .TENS_MAX(TENS_MAX), .UW(UW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_hold_i(in_hold_i), .skip_i(skip_i),
  .units_o(units_o), .tens_o(tens_o), .phase_o(phase_o),
  .storage_flag_o(storage_flag_o), .wrap_o(wrap_o), .status_o(status_o)
);

// File: tb/sim_rdaddr_counter.sv
`timescale 1ns/1ps
module sim_rdaddr_counter;
  localparam int STRETCH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0, gate = 1'b1, hold = 1'b0, skip = 1'b0;
  logic [2:0] preset = 3'b000;
  logic [3:0] units;
  logic [2:0] tens;
  logic       phase, sflag, wrap, status;

  int checks = 0, errors = 0;
  bit done = 0;
  // bench model
  int n = 0;
  bit ph = 1, arm = 0;

  always #4 clk = ~clk;

  rdaddr_counter #(.STRETCH_CYC(STRETCH)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_pulse_i(raw), .scan_gate_i(gate),
    .in_hold_i(hold), .preset_i(preset), .skip_i(skip),
    .units_o(units), .tens_o(tens), .phase_o(phase),
    .storage_flag_o(sflag), .wrap_o(wrap), .status_o(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string tag, input bit exp_wrap);
    check({tag, " units"}, int'(units), n % 10);
    check({tag, " tens"},  int'(tens), n / 10);
    check({tag, " phase"}, int'(phase), int'(ph));
    check({tag, " R9 flag"}, int'(sflag), int'(!ph));
    check({tag, " R5 wrap"}, int'(wrap), int'(exp_wrap));
    check({tag, " R10 status"}, int'(status), int'(exp_wrap && hold));
  endtask

  // one accepted (or gated-off) count, spaced past the stretch window
  task automatic do_count(input bit g, input string tag);
    bit w;
    w = 0;
    @(negedge clk); raw = 1; gate = g;
    @(negedge clk); raw = 0;
    if (g) begin
      if (n == 50) begin
        n = 1; w = 1;
        if (arm) begin ph = 0; arm = 0; end
        else if (hold) ph = 1;
        else ph = !ph;
      end else n++;
    end
    check_state(tag, w);
    repeat (STRETCH) @(negedge clk);
    gate = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_state("R1", 0);

    // R2 R4 R5 R6: free run across several wraps
    for (int i = 0; i < 160; i++) do_count(1, "R2 R4 R6 sweep");

    // R3: gated-off counts
    for (int i = 0; i < 3; i++) do_count(0, "R3 gate");
    // R3: retrigger inside window ignored
    @(negedge clk); raw = 1;
    @(negedge clk); raw = 0;
    if (n == 50) begin n = 1; ph = !ph; end else n++;
    @(negedge clk); raw = 1;
    @(negedge clk); raw = 0;
    check({"R3 retrigger"}, 10 * int'(tens) + int'(units), n);
    repeat (STRETCH + 2) @(negedge clk);
    check({"R3 after window"}, 10 * int'(tens) + int'(units), n);

    // R7 R10: hold keeps input phase across wraps
    hold = 1;
    for (int i = 0; i < 110; i++) do_count(1, "R7 hold");

    // R8: preset under hold forces one output pass
    @(negedge clk); preset = 3'b010; arm = 1;
    @(negedge clk); preset = 3'b000;
    for (int i = 0; i < 110; i++) do_count(1, "R8 preset");
    // R8: a second line, then release hold; pass returns to toggling
    @(negedge clk); preset = 3'b100; arm = 1;
    @(negedge clk); preset = 3'b000;
    for (int i = 0; i < 60; i++) do_count(1, "R8 preset2");
    hold = 0;
    for (int i = 0; i < 60; i++) do_count(1, "R6 release");

    // R11: skip clears units only
    for (int i = 0; i < 7; i++) do_count(1, "R11 pre");
    @(negedge clk); skip = 1;
    @(negedge clk); skip = 0;
    n = (n / 10) * 10;
    check_state("R11 skip", 0);
    // R11: count in the same cycle as skip is dropped
    for (int i = 0; i < 4; i++) do_count(1, "R11 pre2");
    @(negedge clk); skip = 1; raw = 1;
    @(negedge clk); skip = 0; raw = 0;
    n = (n / 10) * 10;
    check_state("R11 skip+count", 0);
    repeat (STRETCH + 1) @(negedge clk);
    for (int i = 0; i < 12; i++) do_count(1, "R11 resume");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule